// File: doc/BRIEF.md
# Dual-Channel Wiper Register I2C Slave

This block is an I2C slave that holds the tap-position codes of two digital potentiometer channels. Channel A has 100 taps (codes 0 to 99). Channel B has 256 taps (codes 0 to 255). A host selects a channel by sending an instruction byte after the device address. It can then write a new code, or read the current code back with a random read. A random read is a pointer-setting write, then a repeated START, then the address with the read bit set.

The bus pins are sampled on the system clock. The slave pulls SDA low only through an open-drain enable. The two wiper codes drive the resistor arrays outside this block. Those arrays, and any nonvolatile storage, are not part of it.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset, both wiper outputs are 00h and `sda_oe_o` is 0.
- R2: An address byte whose upper seven bits are 1010111 is acknowledged: SDA is pulled low during the ninth SCL clock. Bit 0 of that byte is R/W, where 0 means write and 1 means read.
- R3: If the address does not match, the slave does not acknowledge it. SDA stays released until the next START, and no wiper changes.
- R4: Instruction byte bits [1:0] form the channel pointer. Code 01 selects channel A and code 10 selects channel B. A valid pointer is acknowledged.
- R5: Pointer codes 00 and 11 are not acknowledged. The held pointer is kept. A byte that follows a reserved pointer is neither acknowledged nor written.
- R6: In a write, a data byte that follows a valid instruction is acknowledged. It is stored in the selected wiper, which changes exactly 3 system clocks after the SCL falling edge that ends the eighth data bit. At no other time does a wiper change.
- R7: A write to channel A of a value above 99 stores 99. Channel A never holds more than 99.
- R8: After the address is sent with R/W = 1, the slave acknowledges it. It then shifts out the selected wiper code, MSB first, one bit per SCL clock.
- R9: On a read of channel A only bits [6:0] carry meaning. On a read of channel B all 8 bits are valid.
- R10: The last valid pointer is kept between transactions. After reset it selects channel A. A read with no pointer-setting write uses it.
- R11: Instruction bits [7:2] have no effect, in both reads and writes.
- R12: SCL and SDA pass through two synchronizing flops. A START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. A STOP, even in the middle of a byte, returns the slave to idle. The slave changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| wiper_a_o | output | 8 | Channel A tap code (0..99) |
| wiper_b_o | output | 8 | Channel B tap code (0..255) |

## Verification
Every bus event reaches the slave's logic 3 system clocks after it appears at the pins: two synchronizer flops, then one edge-detect flop. So a wiper update is due in the third clock after the SCL fall that ends its data byte. The reference model queues each write with that due cycle and compares both wipers on every falling clock edge. The bench samples ACK and read bits on SDA half an SCL-high phase after the rising edge. By then the slave's drive, which changes 3 clocks after the preceding SCL fall, has long settled.

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c #(
  parameter logic [6:0] DEV_ADDR = 7'b1010111,
  parameter int         TAPS_A   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] wiper_a_o,
  output logic [7:0] wiper_b_o
);

  localparam logic [7:0] A_MAX = 8'(TAPS_A - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_INSTR, S_IACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       rw, sel_b;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire in_idle  = (st == S_IDLE);
  wire rx_state = (st == S_ADDR) || (st == S_INSTR) || (st == S_WDATA);
  wire [1:0] ptr    = sh[1:0];
  wire       ptr_ok = (ptr == 2'b01) || (ptr == 2'b10);
  wire [7:0] cur    = sel_b ? wiper_b_o : wiper_a_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy    <= 2'b11;
      sda_sy    <= 2'b11;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      st        <= S_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      rw        <= 1'b0;
      sel_b     <= 1'b0;
      sda_oe_o  <= 1'b0;
      wiper_a_o <= '0;
      wiper_b_o <= '0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (start_c) begin
        st       <= S_ADDR;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else if (scl_rise) begin
        if (rx_state && bitcnt < 4'd8) begin
          sh     <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == S_RACK) begin
          st <= S_IDLE;
        end
      end else if (scl_fall) begin
        case (st)
          S_ADDR:
            if (bitcnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
                st       <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_INSTR:
            if (bitcnt == 4'd8) begin
              if (ptr_ok) begin
                sda_oe_o <= 1'b1;
                sel_b    <= ptr[1];
                st       <= S_IACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_WDATA:
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b1;
              st       <= S_WACK;
              if (sel_b) wiper_b_o <= sh;
              else       wiper_a_o <= (sh > A_MAX) ? A_MAX : sh;
            end
          S_AACK:
            if (rw) begin
              st       <= S_RDATA;
              sh       <= {cur[6:0], 1'b0};
              sda_oe_o <= ~cur[7];
              bitcnt   <= 4'd1;
            end else begin
              st       <= S_INSTR;
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
            end
          S_IACK: begin
            st       <= S_WDATA;
            sda_oe_o <= 1'b0;
            bitcnt   <= '0;
          end
          S_WACK: begin
            st       <= S_IDLE;
            sda_oe_o <= 1'b0;
          end
          S_RDATA:
            if (bitcnt == 4'd8) begin
              st       <= S_RACK;
              sda_oe_o <= 1'b0;
            end else begin
              sda_oe_o <= ~sh[7];
              sh       <= {sh[6:0], 1'b0};
              bitcnt   <= bitcnt + 4'd1;
            end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_wiper_i2c_chk.sv
module dual_wiper_i2c_chk #(
  parameter int TAPS_A = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       in_idle,
  input logic       sda_oe_o,
  input logic [7:0] wiper_a_o,
  input logic [7:0] wiper_b_o
);

  p_clamp_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_a_o <= 8'(TAPS_A - 1));

  p_wiper_a_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_a_o != $past(wiper_a_o)) |-> $past(scl_fall));

  p_wiper_b_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_b_o != $past(wiper_b_o)) |-> $past(scl_fall));

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe_o);

endmodule

bind dual_wiper_i2c dual_wiper_i2c_chk #(.TAPS_A(TAPS_A)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .in_idle(in_idle), .sda_oe_o(sda_oe_o),
  .wiper_a_o(wiper_a_o), .wiper_b_o(wiper_b_o)
);

// File: tb/dual_wiper_i2c_tb.sv
module dual_wiper_i2c_tb;
  localparam int CLK_P = 10;
  localparam int Q     = 8;
  localparam logic [6:0] DEV = 7'b1010111;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  wire  sda_oe;
  wire [7:0] wa, wb;
  wire  sda_line = sda_m & ~sda_oe;

  always #(CLK_P/2) clk = ~clk;

  dual_wiper_i2c u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wiper_a_o(wa), .wiper_b_o(wb)
  );

  int cyc = 0, checks = 0, errors = 0, last_fall = 0;
  int due_q[$];
  logic [8:0] upd_q[$];
  logic [8:0] ent;
  logic [7:0] exp_a = 0, exp_b = 0;
  bit oe_seen = 0, run_mon = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) if (run_mon) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      ent = upd_q.pop_front();
      void'(due_q.pop_front());
      if (ent[8]) exp_b = ent[7:0]; else exp_a = ent[7:0];
    end
    if (sda_oe) oe_seen = 1;
    chk(wa == exp_a, "R6/R7 wiper_a per clock", wa, exp_a);
    chk(wb == exp_b, "R6 wiper_b per clock", wb, exp_b);
  end

  task automatic tick; @(posedge clk); #(CLK_P/4); endtask
  task automatic wq; repeat (Q) tick(); endtask

  task automatic bit_out(input bit b);
    sda_m = b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; last_fall = cyc;
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1; wq(); scl_m = 1; wq(); b = sda_line; wq(); scl_m = 0; wq();
  endtask

  task automatic byte_out(input logic [7:0] v, input bit upd, input bit ch, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      bit_out(v[i]);
      if (i == 0 && upd) begin
        due_q.push_back(last_fall + 3);
        upd_q.push_back({ch, ch ? v : ((v > 8'd99) ? 8'd99 : v)});
      end
      wq();
    end
    bit_in(r);
    ack = !r;
  endtask

  task automatic byte_in(output logic [7:0] d);
    bit t;
    for (int i = 7; i >= 0; i--) begin
      bit_in(t);
      d[i] = t;
    end
    bit_out(1); wq();
  endtask

  task automatic start_seq;
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic stop_seq;
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); wq();
  endtask

  task automatic write_tx(input logic [7:0] instr, input logic [7:0] data, input bit upd,
                          input bit ch, output bit a1, output bit a2, output bit a3);
    start_seq();
    byte_out({DEV, 1'b0}, 0, 0, a1);
    byte_out(instr, 0, 0, a2);
    byte_out(data, upd, ch, a3);
    stop_seq();
  endtask

  task automatic read_tx(input bit dummy, input logic [7:0] instr, output logic [7:0] d,
                         output bit a1, output bit a2, output bit a3);
    a1 = 1; a2 = 1;
    start_seq();
    if (dummy) begin
      byte_out({DEV, 1'b0}, 0, 0, a1);
      byte_out(instr, 0, 0, a2);
      start_seq();
    end
    byte_out({DEV, 1'b1}, 0, 0, a3);
    byte_in(d);
    stop_seq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cyc);
    finish_up();
  end

  initial begin
    bit a1, a2, a3;
    logic [7:0] d;
    repeat (4) tick();
    chk(wa == 0 && wb == 0, "R1 wipers after reset", {wb, wa}, 0);
    chk(!sda_oe, "R1 sda released after reset", sda_oe, 0);
    rst_n = 1;
    repeat (4) tick();
    run_mon = 1;

    write_tx(8'h02, 8'hA5, 1, 1, a1, a2, a3);
    chk(a1, "R2 address ack", a1, 1);
    chk(a2, "R4 ack pointer 10", a2, 1);
    chk(a3, "R6 data ack channel B", a3, 1);

    write_tx(8'h01, 8'd57, 1, 0, a1, a2, a3);
    chk(a2, "R4 ack pointer 01", a2, 1);
    read_tx(1, 8'h01, d, a1, a2, a3);
    chk(a3, "R8 read address ack", a3, 1);
    chk(d[6:0] == 7'd57, "R9 channel A low bits", d[6:0], 57);

    write_tx(8'h01, 8'd200, 1, 0, a1, a2, a3);
    read_tx(1, 8'h01, d, a1, a2, a3);
    chk(d[6:0] == 7'd99, "R7 clamp of 200", d[6:0], 99);
    write_tx(8'h01, 8'd100, 1, 0, a1, a2, a3);
    chk(wa == 8'd99, "R7 clamp of 100", wa, 99);
    write_tx(8'h01, 8'd99, 1, 0, a1, a2, a3);
    chk(wa == 8'd99, "R7 value 99 kept", wa, 99);

    read_tx(1, 8'h02, d, a1, a2, a3);
    chk(d == 8'hA5, "R8 R9 channel B full byte", d, 8'hA5);

    write_tx(8'h03, 8'h11, 0, 0, a1, a2, a3);
    chk(a1, "R5 address still acked", a1, 1);
    chk(!a2, "R5 pointer 11 not acked", a2, 0);
    chk(!a3, "R5 byte after reserved not acked", a3, 0);
    write_tx(8'h00, 8'h22, 0, 0, a1, a2, a3);
    chk(!a2, "R5 pointer 00 not acked", a2, 0);
    chk(!a3, "R5 byte after pointer 00 not acked", a3, 0);

    read_tx(0, 8'h00, d, a1, a2, a3);
    chk(d == 8'hA5, "R10 held pointer B after reserved codes", d, 8'hA5);
    read_tx(1, 8'h01, d, a1, a2, a3);
    read_tx(0, 8'h00, d, a1, a2, a3);
    chk(d[6:0] == 7'd99, "R10 held pointer A direct read", d[6:0], 99);

    write_tx(8'hFE, 8'h3C, 1, 1, a1, a2, a3);
    chk(a2 && a3, "R11 upper instruction bits ignored in write", {a2, a3}, 3);
    read_tx(1, 8'hFE, d, a1, a2, a3);
    chk(a2 && d == 8'h3C, "R11 upper instruction bits ignored in read", d, 8'h3C);

    oe_seen = 0;
    start_seq();
    byte_out({7'h50, 1'b0}, 0, 0, a1);
    byte_out(8'h02, 0, 0, a2);
    byte_out(8'h77, 0, 0, a3);
    stop_seq();
    chk(!a1, "R3 foreign address not acked", a1, 0);
    chk(!a2 && !a3, "R3 later bytes not acked", {a2, a3}, 0);
    start_seq();
    byte_out({7'h2B, 1'b1}, 0, 0, a1);
    byte_in(d);
    stop_seq();
    chk(d == 8'hFF, "R3 no data driven on foreign read", d, 8'hFF);
    chk(!oe_seen, "R3 SDA never pulled", oe_seen, 0);

    start_seq();
    byte_out({DEV, 1'b0}, 0, 0, a1);
    bit_out(0); wq();
    bit_out(0); wq();
    stop_seq();
    read_tx(0, 8'h00, d, a1, a2, a3);
    chk(a3 && d == 8'h3C, "R12 stop mid-byte returns idle", d, 8'h3C);
    write_tx(8'h01, 8'd0, 1, 0, a1, a2, a3);
    read_tx(0, 8'h00, d, a1, a2, a3);
    chk(d[6:0] == 7'd0, "R12 R10 write after abort", d[6:0], 0);

    repeat (10) tick();
    finish_up();
  end
endmodule